// File: doc/BRIEF.md
# Synchronous Serial Byte Controller (Master/Slave)

This block moves 8-bit words over a four-wire synchronous serial link: a serial clock, one data line per direction and an active-low select. Software configures it through three byte-wide registers on a simple read/write strobe bus. As bus master it produces the serial clock at one of six rates. As slave it takes the clock from the link. In both roles one shift register sends and receives at the same time, and every received word is copied into a separate read buffer. For one-way traffic only two link lines are wired, and the slave can release its output line entirely.

The select seen by the controller comes either from the select pin or from a software bit. A status register carries a word-complete flag and three error flags: a data write during a transfer, a select asserted while the controller is master, and a word completing before the previous one was collected. When interrupts are enabled, any of these raises an interrupt request.

Top module: `spi_port`

## Requirements
- R1: After synchronous reset, all three registers read 0. The clock, data-out and slave-out enables are low, the clock output is 0 and `irq` is 0.
- R2: In master mode a data register write starts a transfer of 8 bits, most significant bit first. The clock idles at the polarity bit. With phase 0, data is sampled on the leading edge and changed on the trailing edge. With phase 1, data is changed on the leading edge and sampled on the trailing edge. The word received on `miso_i` is returned by a later data register read, and the written word appears on `mosi_o`.
- R3: In master mode, rate code k (0 to 5) gives a serial clock half-period of 2^k system clocks, which is a divisor of 2^(k+1). Codes 6 and 7 behave as code 5 (divisor 64).
- R4: In slave mode, while selected, the controller shifts on edges of `sck_i` in the same phase rules as R2. It returns on `miso_o` the word preloaded by a data write and receives the word on `mosi_i`. Each half-period of `sck_i` must last at least 4 system clocks.
- R5: While the output-disable bit is set, `miso_oe` stays low in slave mode and the incoming word is still received.
- R6: With the software-select bit set, the controller is selected when the select-value bit is 0, and the `ss_n_i` pin has no effect. With it clear, `ss_n_i` low selects.
- R7: The end-of-word flag is set when a word completes. It is cleared when a status register read is immediately followed, as the next bus access, by a data register access. Any other access in between breaks the sequence.
- R8: A data write while a transfer is in progress sets the collision flag and leaves the outgoing word unchanged. The same clear sequence as R7 clears this flag.
- R9: Select active while enabled as master sets the mode fault flag and clears the enable and master bits, which stops driving the link. The flag is cleared by a status read followed by a control register write.
- R10: When a word completes while the end-of-word flag is still set, the overrun flag is set and the read buffer keeps the older word. The R7 sequence clears this flag.
- R11: `irq` is high exactly when the interrupt enable bit is set and at least one of the four flags is set.
- R12: Register map. Address 0 is control: bit 7 interrupt enable, bit 6 enable, bit 5 master, bit 4 polarity, bit 3 phase, bits 2:0 rate. Address 1 is status: bit 7 end-of-word, bit 6 collision, bit 5 overrun, bit 4 mode fault, bit 3 reads 0, bit 2 output disable, bit 1 software select, bit 0 select value. Only bits 2:0 of status are writable. Address 2 is data. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives clear sequences) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| sck_i | input | 1 | Serial clock from the link (slave) |
| sck_o | output | 1 | Serial clock driven as master |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Master-to-slave data in (slave) |
| mosi_o | output | 1 | Master-to-slave data out (master) |
| mosi_oe | output | 1 | Master-to-slave data output enable |
| miso_i | input | 1 | Slave-to-master data in (master) |
| miso_o | output | 1 | Slave-to-master data out (slave) |
| miso_oe | output | 1 | Slave-to-master data output enable |
| ss_n_i | input | 1 | Active-low select pin |
| irq | output | 1 | Interrupt request |

## Verification
The master path is driven in all four polarity and phase combinations. Directed word pairs such as single set bits at opposite ends, all ones against all zeros, and alternating patterns expose bit-order and off-by-one-edge faults. Seeded random words, modes and rates then mix these conditions. A rate sweep over all eight codes measures the serial clock half-period, which separates each divisor and the reserved codes. The slave path is driven in each phase mode with pin select, with output disabled, and with software select both choosing and refusing the link. Back-to-back uncollected words, a mid-transfer write, a broken clear sequence and an asserted select while master each exercise one flag rule against its clear condition.

// File: rtl/spi_pkg.sv
package spi_pkg;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    typedef struct packed {
        logic       ie;
        logic       en;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic [2:0] rate;
    } ctrl_t;

    typedef struct packed {
        logic sod;
        logic ssm;
        logic ssi;
    } cfg_t;

    typedef struct packed {
        logic spif;
        logic wcol;
        logic ovr;
        logic modf;
    } flags_t;

    // half-period of the master serial clock in system clocks
    function automatic logic [5:0] half_period(input logic [2:0] code);
        if (code < 3'd6) return 6'd1 << code;
        else             return 6'd32;
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int           W    = 1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [1:0] st;
        always_ff @(posedge clk) begin
            if (rst) st <= {2{INIT[g]}};
            else     st <= {st[0], d[g]};
        end
        assign q[g] = st[1];
    end
endmodule

// File: rtl/spi_mclk.sv
module spi_mclk import spi_pkg::*; #(
    parameter int EDGES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       abort,
    input  logic [2:0] rate,
    output logic       run,
    output logic       lead,
    output logic       trail,
    output logic       phase
);
    localparam int EW = $clog2(EDGES);

    logic [5:0]    tick;
    logic [EW-1:0] ecnt;
    logic          run_q, ph_q, edge_now;

    assign edge_now = run_q && (tick == half_period(rate) - 6'd1);

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            run_q <= 1'b0; tick <= '0; ecnt <= '0; ph_q <= 1'b0;
        end else if (!run_q) begin
            if (start) begin
                run_q <= 1'b1; tick <= '0; ecnt <= '0; ph_q <= 1'b0;
            end
        end else if (edge_now) begin
            tick <= '0;
            ph_q <= ~ph_q;
            ecnt <= ecnt + 1'b1;
            if (ecnt == EW'(EDGES - 1)) run_q <= 1'b0;
        end else begin
            tick <= tick + 6'd1;
        end
    end

    assign run   = run_q;
    assign lead  = edge_now && !ecnt[0];
    assign trail = edge_now &&  ecnt[0];
    assign phase = ph_q;

    // R3
    tick_range_chk: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (tick < half_period(rate)));
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          lead,
    input  logic          trail,
    input  logic          clear,
    input  logic          cpha,
    input  logic          din,
    output logic          out_bit,
    output logic [DW-1:0] sr,
    output logic          busy,
    output logic          done
);
    localparam int CW = $clog2(DW);

    logic [DW-1:0] sr_q;
    logic [CW-1:0] cnt;
    logic          cap, dout, act, done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0; cnt <= '0; cap <= 1'b0; dout <= 1'b0;
            act <= 1'b0; done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load) sr_q <= load_val;
            if (clear) begin
                cnt <= '0;
                act <= 1'b0;
            end else begin
                if (lead) begin
                    act <= 1'b1;
                    if (cpha) dout <= sr_q[DW-1];
                    else      cap  <= din;
                end
                if (trail && act) begin
                    sr_q <= {sr_q[DW-2:0], cpha ? din : cap};
                    cnt  <= cnt + 1'b1;
                    if (cnt == CW'(DW - 1)) begin
                        done_q <= 1'b1;
                        act    <= 1'b0;
                    end
                end
            end
        end
    end

    assign out_bit = cpha ? dout : sr_q[DW-1];
    assign sr      = sr_q;
    assign busy    = act;
    assign done    = done_q;

    // R2
    word_end_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (cnt == '0) && !act);
endmodule

// File: rtl/spi_port.sv
module spi_port import spi_pkg::*; #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              ss_n_i,
    output logic              irq
);
    localparam int EDGES = 2 * DATA_W;

    ctrl_t             ctrl_q;
    cfg_t              cfg_q;
    flags_t            flags_q;
    logic [DATA_W-1:0] rbuf;
    logic              arm_q;

    logic [2:0] pin_s;
    logic       ss_n_s, sck_s, mosi_s, sck_d;

    spi_sync #(.W(3), .INIT(3'b100)) u_sync (
        .clk(clk), .rst(rst), .d({ss_n_i, sck_i, mosi_i}), .q(pin_s));
    assign {ss_n_s, sck_s, mosi_s} = pin_s;

    always_ff @(posedge clk) begin
        if (rst) sck_d <= 1'b0;
        else     sck_d <= sck_s;
    end

    logic master_on, sel_act, s_sel, modf_evt;
    logic s_rise, s_fall, s_lead, s_trail;
    assign master_on = ctrl_q.en && ctrl_q.master;
    assign sel_act   = cfg_q.ssm ? !cfg_q.ssi : !ss_n_s;
    assign s_sel     = ctrl_q.en && !ctrl_q.master && sel_act;
    assign modf_evt  = master_on && sel_act;
    assign s_rise    = sck_s && !sck_d;
    assign s_fall    = !sck_s && sck_d;
    assign s_lead    = s_sel && (ctrl_q.cpol ? s_fall : s_rise);
    assign s_trail   = s_sel && (ctrl_q.cpol ? s_rise : s_fall);

    logic wr_ctrl, wr_stat, wr_data, clr_xfer, busy, wcol_evt, load;
    logic m_run, m_lead, m_trail, m_phase;
    logic sh_lead, sh_trail, sh_out, sh_busy, sh_done;
    logic [DATA_W-1:0] sh_sr;

    assign wr_ctrl  = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_stat  = bus_wr && (bus_addr == ADDR_STAT);
    assign wr_data  = bus_wr && (bus_addr == ADDR_DATA);
    assign clr_xfer = arm_q && (bus_wr || bus_rd) && (bus_addr == ADDR_DATA);
    assign busy     = m_run || sh_busy;
    assign wcol_evt = wr_data && busy;
    assign load     = wr_data && !busy;

    spi_mclk #(.EDGES(EDGES)) u_mclk (
        .clk(clk), .rst(rst), .start(load && master_on),
        .abort(!master_on || modf_evt), .rate(ctrl_q.rate),
        .run(m_run), .lead(m_lead), .trail(m_trail), .phase(m_phase));

    assign sh_lead  = master_on ? m_lead  : s_lead;
    assign sh_trail = master_on ? m_trail : s_trail;

    spi_shifter #(.DW(DATA_W)) u_shift (
        .clk(clk), .rst(rst), .load(load), .load_val(bus_wdata),
        .lead(sh_lead), .trail(sh_trail), .clear(!master_on && !s_sel),
        .cpha(ctrl_q.cpha), .din(master_on ? miso_i : mosi_s),
        .out_bit(sh_out), .sr(sh_sr), .busy(sh_busy), .done(sh_done));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0; cfg_q <= '0; flags_q <= '0; rbuf <= '0; arm_q <= 1'b0;
        end else begin
            if (bus_wr || bus_rd) arm_q <= bus_rd && (bus_addr == ADDR_STAT);
            if (wr_ctrl) begin
                ctrl_q <= ctrl_t'(bus_wdata[7:0]);
                if (arm_q) flags_q.modf <= 1'b0;
            end
            if (wr_stat) cfg_q <= cfg_t'(bus_wdata[2:0]);
            if (clr_xfer) begin
                flags_q.spif <= 1'b0;
                flags_q.wcol <= 1'b0;
                flags_q.ovr  <= 1'b0;
            end
            if (wcol_evt) flags_q.wcol <= 1'b1;
            if (sh_done) begin
                if (flags_q.spif && !clr_xfer) begin
                    flags_q.ovr <= 1'b1;
                end else begin
                    flags_q.spif <= 1'b1;
                    rbuf         <= sh_sr;
                end
            end
            if (modf_evt) begin
                flags_q.modf  <= 1'b1;
                ctrl_q.en     <= 1'b0;
                ctrl_q.master <= 1'b0;
            end
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_CTRL: bus_rdata = DATA_W'(ctrl_q);
            ADDR_STAT: bus_rdata = DATA_W'({flags_q, 1'b0, cfg_q});
            ADDR_DATA: bus_rdata = rbuf;
            default:   bus_rdata = '0;
        endcase
    end

    assign sck_o   = master_on ? (ctrl_q.cpol ^ m_phase) : ctrl_q.cpol;
    assign sck_oe  = master_on;
    assign mosi_o  = sh_out;
    assign mosi_oe = master_on;
    assign miso_o  = sh_out;
    assign miso_oe = s_sel && !cfg_q.sod;
    assign irq     = ctrl_q.ie && (|flags_q);

    // R2
    edge_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(sh_lead && sh_trail));
    // R5
    oe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(sck_oe && miso_oe));
    // R7
    spif_set_chk: assert property (@(posedge clk) disable iff (rst)
        sh_done |=> flags_q.spif);
    // R8
    wcol_set_chk: assert property (@(posedge clk) disable iff (rst)
        wcol_evt |=> flags_q.wcol);
    // R9
    modf_stop_chk: assert property (@(posedge clk) disable iff (rst)
        modf_evt |=> (flags_q.modf && !sck_oe && !mosi_oe));
    // R10
    ovr_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (sh_done && flags_q.spif && !clr_xfer) |=> (flags_q.ovr && $stable(rbuf)));
endmodule

// File: tb/spi_port_tb.sv
module spi_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SLV_HALF   = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n_i = 1'b1;
    logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, irq;

    int n_chk = 0;
    int n_fail = 0;

    spi_port u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
        .ss_n_i(ss_n_i), .irq(irq));

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int exp_half(input int r);
        return (r < 6) ? (1 << r) : 32;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic master_xfer(input logic ie, input logic cpol, input logic cpha,
                               input logic [2:0] rate, input logic [7:0] tx,
                               input logic [7:0] sl, input logic do_clear,
                               input logic collide, input logic exp_ovr,
                               input string tag);
        logic [7:0] cap, rd;
        logic       prev;
        int e, cyc, t0, t1;
        bus_write(2'd0, {ie, 1'b1, 1'b1, cpol, cpha, rate});
        check("R2", {tag, " idle clock level"}, sck_o, cpol);
        miso_i = cpha ? 1'b0 : sl[7];
        bus_write(2'd2, tx);
        prev = sck_o; e = 0; cyc = 0; cap = 8'd0; t0 = 0; t1 = 0;
        while (e < 16 && cyc < 5000) begin
            @(negedge clk); cyc++;
            if (sck_o !== prev) begin
                prev = sck_o;
                if (e == 0) t0 = cyc;
                if (e == 1) t1 = cyc;
                if (e % 2 == 0) begin
                    if (!cpha) cap = {cap[6:0], mosi_o};
                    else       miso_i = sl[7 - e / 2];
                end else begin
                    if (cpha)        cap = {cap[6:0], mosi_o};
                    else if (e < 15) miso_i = sl[7 - (e + 1) / 2];
                end
                e++;
                if (collide && e == 4) bus_write(2'd2, ~tx);
            end
        end
        repeat (4) @(negedge clk);
        check("R2", {tag, " edge count"}, e, 16);
        check("R3", {tag, " half period"}, t1 - t0, exp_half(int'(rate)));
        check(collide ? "R8" : "R2", {tag, " word on mosi"}, cap, tx);
        check("R2", {tag, " clock back to idle"}, sck_o, cpol);
        bus_read(2'd1, rd);
        check(exp_ovr ? "R10" : (collide ? "R8" : "R7"), {tag, " status flags"},
              rd, {1'b1, collide, exp_ovr, 5'b0});
        check("R11", {tag, " irq with flag"}, irq, ie);
        if (do_clear) begin
            bus_read(2'd2, rd);
            check("R2", {tag, " received word"}, rd, sl);
            bus_read(2'd1, rd);
            check("R7", {tag, " flags cleared"}, rd, 8'h00);
            check("R11", {tag, " irq after clear"}, irq, 1'b0);
        end
    endtask

    task automatic slave_xfer(input logic cpol, input logic cpha, input logic [7:0] tx,
                              input logic [7:0] mtx, input logic pin_sel,
                              input logic exp_sel, input logic exp_oe,
                              input string req, input string tag);
        logic [7:0] got, rd;
        logic       oe_ok;
        sck_i = cpol; mosi_i = 1'b0;
        repeat (4) @(negedge clk);
        bus_write(2'd0, {1'b0, 1'b1, 1'b0, cpol, cpha, 3'd0});
        bus_write(2'd2, tx);
        if (pin_sel) ss_n_i = 1'b0;
        repeat (8) @(negedge clk);
        got = 8'd0; oe_ok = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            if (!cpha) begin
                mosi_i = mtx[i];
                repeat (SLV_HALF) @(negedge clk);
                got[i] = miso_o;
                if (miso_oe !== exp_oe) oe_ok = 1'b0;
                sck_i = ~cpol;
                repeat (SLV_HALF) @(negedge clk);
                sck_i = cpol;
            end else begin
                sck_i = ~cpol; mosi_i = mtx[i];
                repeat (SLV_HALF) @(negedge clk);
                got[i] = miso_o;
                if (miso_oe !== exp_oe) oe_ok = 1'b0;
                sck_i = cpol;
                repeat (SLV_HALF) @(negedge clk);
            end
        end
        repeat (8) @(negedge clk);
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
        check(req, {tag, " miso enable"}, oe_ok, 1'b1);
        bus_read(2'd1, rd);
        check(req, {tag, " end-of-word flag"}, rd[7], exp_sel);
        if (exp_sel) begin
            bus_read(2'd2, rd);
            check(req, {tag, " received word"}, rd, mtx);
            if (exp_oe) check("R4", {tag, " word on miso"}, got, tx);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog expired: got hang expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int seed;
        seed = $urandom(32'h5e1f);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        bus_read(2'd0, rd); check("R1", "control after reset", rd, 8'h00);
        bus_read(2'd1, rd); check("R1", "status after reset", rd, 8'h00);
        bus_read(2'd2, rd); check("R1", "data after reset", rd, 8'h00);
        check("R1", "output enables", {sck_oe, mosi_oe, miso_oe}, 3'b000);
        check("R1", "clock and irq", {sck_o, irq}, 2'b00);

        // R12 register layout
        bus_write(2'd0, 8'h9B);
        bus_read(2'd0, rd); check("R12", "control readback", rd, 8'h9B);
        check("R11", "irq with no flag", irq, 1'b0);
        bus_write(2'd1, 8'hFF);
        bus_read(2'd1, rd); check("R12", "status writable bits", rd, 8'h07);
        bus_read(2'd3, rd); check("R12", "unused address", rd, 8'h00);
        bus_write(2'd1, 8'h00);
        bus_write(2'd0, 8'h00);

        // R2 all four modes
        master_xfer(1'b0, 1'b0, 1'b0, 3'd0, 8'hA5, 8'h3C, 1'b1, 1'b0, 1'b0, "mode0");
        master_xfer(1'b1, 1'b0, 1'b1, 3'd0, 8'h80, 8'h01, 1'b1, 1'b0, 1'b0, "mode1");
        master_xfer(1'b0, 1'b1, 1'b0, 3'd1, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b0, "mode2");
        master_xfer(1'b1, 1'b1, 1'b1, 3'd1, 8'h00, 8'hFF, 1'b1, 1'b0, 1'b0, "mode3");

        // R3 rate sweep
        for (int r = 0; r < 8; r++)
            master_xfer(1'b0, 1'b0, r[0], r[2:0], 8'($urandom()), 8'($urandom()),
                        1'b1, 1'b0, 1'b0, "rate");

        // R7 broken clear sequence
        master_xfer(1'b0, 1'b0, 1'b0, 3'd0, 8'h5A, 8'hC3, 1'b0, 1'b0, 1'b0, "brk");
        bus_read(2'd0, rd);
        bus_read(2'd2, rd);
        bus_read(2'd1, rd); check("R7", "flag survives broken sequence", rd[7], 1'b1);
        bus_read(2'd2, rd);
        bus_read(2'd1, rd); check("R7", "flag cleared by sequence", rd[7], 1'b0);

        // R10 overrun keeps older word
        master_xfer(1'b1, 1'b0, 1'b0, 3'd0, 8'h11, 8'h6E, 1'b0, 1'b0, 1'b0, "ovr1");
        master_xfer(1'b1, 1'b0, 1'b0, 3'd0, 8'h22, 8'h91, 1'b0, 1'b0, 1'b1, "ovr2");
        bus_read(2'd2, rd); check("R10", "buffer keeps older word", rd, 8'h6E);
        bus_read(2'd1, rd); check("R10", "overrun cleared", rd, 8'h00);

        // R8 collision
        master_xfer(1'b1, 1'b0, 1'b1, 3'd3, 8'hC9, 8'h47, 1'b1, 1'b1, 1'b0, "wcol");

        // R9 mode fault
        bus_write(2'd0, 8'hE0);
        ss_n_i = 1'b0;
        repeat (5) @(negedge clk);
        check("R11", "irq on mode fault", irq, 1'b1);
        check("R9", "link released", {sck_oe, mosi_oe}, 2'b00);
        bus_read(2'd0, rd); check("R9", "enable and master cleared", rd, 8'h80);
        bus_read(2'd1, rd); check("R9", "mode fault flag", rd, 8'h10);
        bus_write(2'd0, 8'h00);
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
        bus_read(2'd1, rd); check("R9", "mode fault cleared", rd, 8'h00);

        // R4 slave modes with pin select
        slave_xfer(1'b0, 1'b0, 8'hB4, 8'h2D, 1'b1, 1'b1, 1'b1, "R4", "slv0");
        slave_xfer(1'b0, 1'b1, 8'h01, 8'h80, 1'b1, 1'b1, 1'b1, "R4", "slv1");
        slave_xfer(1'b1, 1'b0, 8'hE7, 8'h18, 1'b1, 1'b1, 1'b1, "R4", "slv2");
        slave_xfer(1'b1, 1'b1, 8'h6C, 8'hF3, 1'b1, 1'b1, 1'b1, "R4", "slv3");

        // R5 output disabled
        bus_write(2'd0, 8'h00);
        bus_write(2'd1, 8'h04);
        slave_xfer(1'b0, 1'b0, 8'h99, 8'h5C, 1'b1, 1'b1, 1'b0, "R5", "sod");

        // R6 software select chooses the link, pin held high
        bus_write(2'd0, 8'h00);
        bus_write(2'd1, 8'h02);
        slave_xfer(1'b0, 1'b1, 8'h3A, 8'hA3, 1'b0, 1'b1, 1'b1, "R6", "ssm_on");

        // R6 software select refuses the link, pin driven low
        bus_write(2'd0, 8'h00);
        bus_write(2'd1, 8'h03);
        slave_xfer(1'b0, 1'b0, 8'h4B, 8'h77, 1'b1, 1'b0, 1'b0, "R6", "ssm_off");
        bus_write(2'd0, 8'h00);
        bus_write(2'd1, 8'h00);

        // R2 random master transfers
        for (int k = 0; k < 10; k++) begin
            logic [3:0] m;
            m = 4'($urandom());
            master_xfer(m[3], m[0], m[1], 3'($urandom()), 8'($urandom()),
                        8'($urandom()), 1'b1, 1'b0, 1'b0, "rnd");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule